// File: doc/BRIEF.md
# ADC Ramp Pattern Checker

This block qualifies the digital interface of a dual-channel converter while the converter drives an incrementing ramp test pattern. It has two independent lanes, one for the in-phase samples and one for the quadrature samples. Software puts one channel into ramp mode and holds the other at all ones, then checks each lane on its own. Because of this, a ramp that arrives on the wrong lane cannot lock the lane under test.

Each lane starts in a searching state. A zero sample that is marked valid while the lane is enabled moves the lane to tracking, and the lane raises its lock flag. From then on the lane keeps its own expected value and adds one to a saturating error count for every valid sample that differs from that value. The expected value always advances from the previous expected value, so a single bad sample costs exactly one error. Taking the enable low clears the lane. Raising it again starts a fresh search for zero.

Top module: `adc_ramp_checker`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, both lock flags read 0 and both error counts read 0.
- R2: A lane that is enabled but not locked neither locks nor counts errors on valid samples that are not equal to zero.
- R3: An enabled lane that accepts a valid sample equal to 0 shows lock = 1 on the clock edge that accepts that sample, and keeps it while enable stays high.
- R4: A locked lane adds exactly 1 to its error count for each valid sample that differs from its expected value, and adds nothing for a valid sample that matches.
- R5: The first expected value after the zero sample is 1. Each accepted valid sample then advances the expected value by one, modulo 2^SAMPLE_W, so the value after 2^SAMPLE_W-1 is 0.
- R6: After a mismatch, the next expected value is the previous expected value plus one, not the received sample plus one.
- R7: A sample with valid = 0 changes neither the lock flag, the error count nor the expected value of a lane.
- R8: While chk_en is low, both lock flags and both error counts read 0 from the next cycle on. After chk_en rises again, a lane stays unlocked until it sees a new valid zero.
- R9: Samples presented while chk_en is low, including zeros marked valid, do not lock a lane.
- R10: The error count is ERR_W bits wide (default 32) and holds at 2^ERR_W-1 instead of wrapping.
- R11: The in-phase and quadrature lanes keep separate lock flags and error counts, and samples on one lane never affect the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en | input | 1 | Checker enable for both lanes; low clears them |
| smp_valid | input | 1 | Marks the current sample pair as valid |
| smp_i | input | SAMPLE_W | In-phase sample |
| smp_q | input | SAMPLE_W | Quadrature sample |
| lock_i | output | 1 | In-phase lane has seen zero and is tracking |
| lock_q | output | 1 | Quadrature lane has seen zero and is tracking |
| errs_i | output | ERR_W | In-phase mismatch count, saturating |
| errs_q | output | ERR_W | Quadrature mismatch count, saturating |

## Verification
The hardest states to reach from the ports are the modulo wrap of the expected value and the saturated error count. Both need long runs of valid samples after lock. The bench therefore builds the design with a narrow sample width and a narrow counter. It then streams a correct ramp past one full period, so the expected value wraps, and streams a long run of wrong samples, so the counter reaches its ceiling. A single wrong sample followed by correct ones shows that tracking continues from the expected value and not from the received one.

// File: rtl/adc_ramp_chk_pkg.sv
package adc_ramp_chk_pkg;

   typedef enum logic [0:0] {
      LANE_SEARCH = 1'b0,
      LANE_TRACK  = 1'b1
   } lane_state_e;

endpackage

// File: rtl/ramp_err_counter.sv
module ramp_err_counter #(
   parameter int ERR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bump,
   output logic [ERR_W-1:0] count
);
   localparam logic [ERR_W-1:0] CNT_MAX = '1;
   localparam logic [ERR_W-1:0] CNT_ONE = ERR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (bump && (count != CNT_MAX)) begin
         count <= count + CNT_ONE;
      end
   end
endmodule

// File: rtl/ramp_lane.sv
module ramp_lane
   import adc_ramp_chk_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int ERR_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                valid,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                locked,
   output logic [ERR_W-1:0]    err_cnt
);
   localparam logic [SAMPLE_W-1:0] STEP = SAMPLE_W'(1);

   lane_state_e         state_q;
   logic [SAMPLE_W-1:0] expect_q;
   logic                miss;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= LANE_SEARCH;
         expect_q <= '0;
      end else if (!en) begin
         state_q  <= LANE_SEARCH;
         expect_q <= '0;
      end else if (valid) begin
         unique case (state_q)
            LANE_SEARCH: begin
               if (sample == '0) begin
                  state_q  <= LANE_TRACK;
                  expect_q <= STEP;
               end
            end
            LANE_TRACK: begin
               expect_q <= expect_q + STEP;
            end
            default: state_q <= LANE_SEARCH;
         endcase
      end
   end

   assign miss   = en && valid && (state_q == LANE_TRACK) && (sample != expect_q);
   assign locked = (state_q == LANE_TRACK);

   ramp_err_counter #(.ERR_W(ERR_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!en),
      .bump  (miss),
      .count (err_cnt)
   );
endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker #(
   parameter int SAMPLE_W = 14,
   parameter int ERR_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chk_en,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic [SAMPLE_W-1:0] smp_q,
   output logic                lock_i,
   output logic                lock_q,
   output logic [ERR_W-1:0]    errs_i,
   output logic [ERR_W-1:0]    errs_q
);
   localparam int NUM_LANES = 2;

   if (SAMPLE_W < 2) begin : g_bad_sample_w
      $error("SAMPLE_W must be at least 2");
   end
   if (ERR_W < 2) begin : g_bad_err_w
      $error("ERR_W must be at least 2");
   end

   logic [NUM_LANES-1:0][SAMPLE_W-1:0] lane_smp;
   logic [NUM_LANES-1:0]               lane_lock;
   logic [NUM_LANES-1:0][ERR_W-1:0]    lane_err;

   assign lane_smp[0] = smp_i;
   assign lane_smp[1] = smp_q;

   for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      ramp_lane #(
         .SAMPLE_W (SAMPLE_W),
         .ERR_W    (ERR_W)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (chk_en),
         .valid   (smp_valid),
         .sample  (lane_smp[ln]),
         .locked  (lane_lock[ln]),
         .err_cnt (lane_err[ln])
      );
   end

   assign lock_i = lane_lock[0];
   assign lock_q = lane_lock[1];
   assign errs_i = lane_err[0];
   assign errs_q = lane_err[1];
endmodule

// File: rtl/adc_ramp_checker_sva.sv
module adc_ramp_checker_sva #(
   parameter int SAMPLE_W = 14,
   parameter int ERR_W    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                chk_en,
   input logic                smp_valid,
   input logic [SAMPLE_W-1:0] smp_i,
   input logic [SAMPLE_W-1:0] smp_q,
   input logic                lock_i,
   input logic                lock_q,
   input logic [ERR_W-1:0]    errs_i,
   input logic [ERR_W-1:0]    errs_q
);
   localparam logic [ERR_W-1:0] E_MAX = '1;
   localparam logic [ERR_W-1:0] E_ONE = ERR_W'(1);

   a_r3_lock_i_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_i) |-> $past((smp_i == '0) && smp_valid && chk_en));
   a_r3_lock_q_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past((smp_q == '0) && smp_valid && chk_en));

   a_r8_clear_i: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> (!lock_i && (errs_i == '0)));
   a_r8_clear_q: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> (!lock_q && (errs_q == '0)));

   a_r7_hold_i: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !smp_valid) |=> ($stable(errs_i) && $stable(lock_i)));
   a_r7_hold_q: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !smp_valid) |=> ($stable(errs_q) && $stable(lock_q)));

   a_r4_step_i: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |=> ((errs_i == $past(errs_i)) || (errs_i == $past(errs_i) + E_ONE)));
   a_r4_unlocked_no_err_i: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !lock_i) |=> (errs_i == $past(errs_i)));

   a_r10_sat_i: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && (errs_i == E_MAX)) |=> (errs_i == E_MAX));
   a_r10_sat_q: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && (errs_q == E_MAX)) |=> (errs_q == E_MAX));
endmodule

bind adc_ramp_checker adc_ramp_checker_sva #(
   .SAMPLE_W (SAMPLE_W),
   .ERR_W    (ERR_W)
) u_sva (.*);

// File: tb/adc_ramp_checker_tb_top.sv
`timescale 1ns/1ps
module adc_ramp_checker_tb_top;
   localparam int SW    = 6;
   localparam int EW    = 5;
   localparam int MODV  = 1 << SW;
   localparam int EMAX  = (1 << EW) - 1;
   localparam int ONES  = MODV - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk_en = 1'b0;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_i = '0;
   logic [SW-1:0] smp_q = '0;
   logic          lock_i, lock_q;
   logic [EW-1:0] errs_i, errs_q;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 0;
   string phase  = "R1";

   int m_lock [2];
   int m_exp  [2];
   int m_err  [2];

   always #5 clk = ~clk;

   adc_ramp_checker #(.SAMPLE_W(SW), .ERR_W(EW)) dut_i (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .smp_valid(smp_valid),
      .smp_i(smp_i), .smp_q(smp_q), .lock_i(lock_i), .lock_q(lock_q),
      .errs_i(errs_i), .errs_q(errs_q)
   );

   // behavioural reference, updated at each active edge
   always @(posedge clk or negedge rst_n) begin
      for (int c = 0; c < 2; c++) begin
         int s;
         s = (c == 0) ? int'(smp_i) : int'(smp_q);
         if (!rst_n || !chk_en) begin
            m_lock[c] = 0; m_exp[c] = 0; m_err[c] = 0;
         end else if (smp_valid) begin
            if (m_lock[c] == 0) begin
               if (s == 0) begin m_lock[c] = 1; m_exp[c] = 1; end
            end else begin
               if (s != m_exp[c] && m_err[c] < EMAX) m_err[c] = m_err[c] + 1;
               m_exp[c] = (m_exp[c] + 1) % MODV;
            end
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
      end
   endtask

   // compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (!done) begin
         check({phase, " lock_i"}, int'(lock_i), m_lock[0]);
         check({phase, " lock_q"}, int'(lock_q), m_lock[1]);
         check({phase, " errs_i"}, int'(errs_i), m_err[0]);
         check({phase, " errs_q"}, int'(errs_q), m_err[1]);
      end
   end

   task automatic drive(input bit e, input bit v, input int a, input int b);
      @(posedge clk); #2;
      chk_en = e; smp_valid = v; smp_i = a[SW-1:0]; smp_q = b[SW-1:0];
   endtask

   // let the last driven sample be taken, then sit at the falling edge
   task automatic settle(input bit e);
      drive(e, 1'b0, 0, 0);
      @(negedge clk);
   endtask

   task automatic wrap_up();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      wrap_up();
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 lock_i in reset", int'(lock_i), 0);
      check("R1 errs_i in reset", int'(errs_i), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 lock_q after reset", int'(lock_q), 0);
      check("R1 errs_q after reset", int'(errs_q), 0);

      // R2: nonzero samples do not lock
      phase = "R2";
      for (int k = 5; k < 15; k++) drive(1, 1, k, ONES);
      settle(1);
      check("R2 lock_i", int'(lock_i), 0);
      check("R2 errs_i", int'(errs_i), 0);

      // R3: zero locks; R11 q lane held at ones stays unlocked
      phase = "R3";
      drive(1, 1, 0, ONES);
      settle(1);
      check("R3 lock_i", int'(lock_i), 1);
      check("R11 lock_q", int'(lock_q), 0);

      // R5: correct ramp through the wrap point
      phase = "R5";
      for (int k = 1; k <= MODV + 5; k++) drive(1, 1, k % MODV, ONES);
      settle(1);
      check("R5 errs_i after wrap", int'(errs_i), 0);

      // R7: invalid garbage ignored, ramp resumes at 6
      phase = "R7";
      for (int k = 0; k < 3; k++) drive(1, 0, 33, 0);
      drive(1, 1, 6, ONES);
      drive(1, 1, 7, ONES);
      settle(1);
      check("R7 errs_i", int'(errs_i), 0);
      check("R7 lock_q", int'(lock_q), 0);

      // R4/R6: one bad sample then expected 9,10
      phase = "R6";
      drive(1, 1, 50, ONES);
      drive(1, 1, 9, ONES);
      drive(1, 1, 10, ONES);
      settle(1);
      check("R4 errs_i single miss", int'(errs_i), 1);
      check("R6 no follow-on errors", int'(errs_i), 1);

      // R11: q lane locks and counts on its own
      phase = "R11";
      drive(1, 1, 11, 0);
      drive(1, 1, 12, 1);
      drive(1, 1, 13, 2);
      drive(1, 1, 14, 40);
      drive(1, 1, 15, 4);
      settle(1);
      check("R11 lock_q", int'(lock_q), 1);
      check("R11 errs_q", int'(errs_q), 1);
      check("R11 errs_i unchanged", int'(errs_i), 1);

      // R8/R9: disabled, valid zeros do not lock, state cleared
      phase = "R9";
      for (int k = 0; k < 3; k++) drive(0, 1, 0, 0);
      settle(0);
      check("R8 lock_i cleared", int'(lock_i), 0);
      check("R8 errs_i cleared", int'(errs_i), 0);
      check("R9 lock_q while disabled", int'(lock_q), 0);

      // R8: re-enabled, search restarts
      phase = "R8";
      drive(1, 1, 3, 7);
      drive(1, 1, 4, 7);
      drive(1, 1, 5, 7);
      settle(1);
      check("R8 lock_i after restart", int'(lock_i), 0);
      check("R8 errs_i after restart", int'(errs_i), 0);

      // R10: saturation
      phase = "R10";
      drive(1, 1, 0, 0);
      for (int k = 0; k < 40; k++) drive(1, 1, 60, 5);
      settle(1);
      check("R10 errs_i saturated", int'(errs_i), EMAX);
      check("R10 errs_q saturated", int'(errs_q), EMAX);
      check("R10 lock_i", int'(lock_i), 1);

      wrap_up();
   end
endmodule